// File: doc/BRIEF.md
# Round-Robin Interrupt Flag Scanner

The block keeps a bank of event flags for a group of serial lines, four flags per line: received character, transmit done, carrier up and carrier down. Line front-ends pulse a one-cycle input to set a flag. A scanner walks the bank in circular order, one slot per clock. When it lands on a set flag it stops, locks, and raises the interrupt request level that belongs to that flag's kind.

The host services the request by pulsing a read strobe. The block then returns the line number of the locked slot, clears that slot, drops the request and resumes the walk from the following slot. Every pending flag is therefore served in rotating order and no line can starve the others. A per-line reset input wipes one line's four flags without touching the rest. The character path, the line status bits and the host bus live outside this block.

Top module: `evt_scanner`

## Requirements
- R1: Slot index is line*4 + kind, with kind 0 = receive, 1 = transmit done, 2 = carrier on, 3 = carrier off. When locked, `irq` has only bit `kind` set and `rd_line` shows the slot's line.
- R2: The scan checks one slot per clock, starting at the slot after the pointer. After reset the pointer sits at the last slot. With the block idle and the pointer at q, an event at slot p sampled on edge k locks the scanner on edge k+d, where d = (p-q) mod 128 and d = 128 when p = q.
- R3: The pointer wraps from slot 127 to slot 0 and continues there.
- R4: On finding a set flag the scanner locks. While locked, `irq` stays one-hot, `busy` is low and the lock holds until a read.
- R5: While locked, new events are stored but start no scan. `irq` and `rd_line` stay unchanged and `busy` stays low.
- R6: A read while locked clears the locked flag and restarts the scan from the next slot (`busy` high on the following cycle). Pending flags are served in circular order from there.
- R7: A read while not locked has no effect. Outputs stay idle and the pointer does not move.
- R8: A scan that meets no set flag runs for exactly 128 cycles with `busy` high, then goes idle with `irq` zero.
- R9: An event that arrives during a scan restarts the scan's length count, so a flag set behind the pointer is still found.
- R10: `line_rst` clears only that line's four flags and leaves a held lock in place. An event set on the same line in the same cycle wins over the clear.
- R11: Reset clears all flags and all requests. `busy` is low and `rd_line` is zero after reset.
- R12: `rd_line` reads zero whenever no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_evt | input | LINES | Per-line receive event pulse |
| tx_evt | input | LINES | Per-line transmit-done event pulse |
| con_evt | input | LINES | Per-line carrier-on event pulse |
| coff_evt | input | LINES | Per-line carrier-off event pulse |
| line_rst | input | LINES | Per-line clear of that line's four flags |
| rd_stb | input | 1 | Host read strobe, acts only while locked |
| rd_line | output | log2(LINES) | Line number of the locked slot, zero when not locked |
| irq | output | 4 | Interrupt request levels, one per flag kind |
| busy | output | 1 | Scan in progress |

## Verification
The bench builds the block with its default of 32 lines, which gives 128 slots. At that size the wrap from slot 127 to slot 0, a full empty 128-cycle circle and exact per-slot latency can all be reached within a few thousand cycles. Service order is checked with several flags pending at once, including flags added while locked and while scanning. The bench also checks a line clear that races an event in the same cycle.

// File: rtl/evt_scan_pkg.sv
`timescale 1ns/1ps
package evt_scan_pkg;

  localparam int unsigned KINDS  = 4;
  localparam int unsigned KIND_W = 2;

  typedef enum logic [1:0] {
    EVK_RX   = 2'd0,
    EVK_TX   = 2'd1,
    EVK_CON  = 2'd2,
    EVK_COFF = 2'd3
  } evt_kind_e;

  typedef enum logic [1:0] {
    SC_IDLE   = 2'd0,
    SC_SEARCH = 2'd1,
    SC_HELD   = 2'd2
  } scan_state_e;

  // slot number of a (line, kind) pair
  function automatic int unsigned slot_of(input int unsigned line, input int unsigned kind);
    return line * KINDS + kind;
  endfunction

  // circular successor of a slot in a ring of 'total' slots
  function automatic int unsigned step_fwd(input int unsigned p, input int unsigned total);
    return (p + 1 == total) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/evt_flag_bank.sv
`timescale 1ns/1ps
module evt_flag_bank #(
  parameter int unsigned SLOTS = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] set_mask,
  input  logic [SLOTS-1:0] clr_mask,
  output logic [SLOTS-1:0] flags
);

  // set wins over clear in the same cycle
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        flags[s] <= 1'b0;
      else if (set_mask[s])
        flags[s] <= 1'b1;
      else if (clr_mask[s])
        flags[s] <= 1'b0;
    end
  end

endmodule

// File: rtl/evt_scan_ctrl.sv
`timescale 1ns/1ps
module evt_scan_ctrl
  import evt_scan_pkg::*;
#(
  parameter int unsigned SLOTS = 128,
  localparam int unsigned PW   = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] flags,
  input  logic [SLOTS-1:0] rst_mask,
  input  logic             any_set,
  input  logic             rd_stb,
  output logic [PW-1:0]    ptr,
  output logic             held,
  output logic             busy,
  output logic             take,
  output logic             hit
);

  scan_state_e   state;
  logic [PW-1:0] cnt;
  logic [PW-1:0] nxt;
  logic          circle_done;

  assign nxt         = PW'(step_fwd(int'(ptr), SLOTS));
  assign hit         = (state == SC_SEARCH) && flags[nxt] && !rst_mask[nxt];
  assign circle_done = (cnt == PW'(SLOTS - 1));
  assign held        = (state == SC_HELD);
  assign busy        = (state == SC_SEARCH);
  assign take        = held && rd_stb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SC_IDLE;
      ptr   <= PW'(SLOTS - 1);
      cnt   <= '0;
    end else begin
      unique case (state)
        SC_IDLE: begin
          if (any_set) begin
            state <= SC_SEARCH;
            cnt   <= '0;
          end
        end
        SC_SEARCH: begin
          ptr <= nxt;
          if (hit) begin
            state <= SC_HELD;
          end else if (any_set) begin
            cnt <= '0;
          end else if (circle_done) begin
            state <= SC_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SC_HELD: begin
          if (rd_stb) begin
            state <= SC_SEARCH;
            cnt   <= '0;
          end
        end
        default: state <= SC_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/evt_irq_steer.sv
`timescale 1ns/1ps
module evt_irq_steer
  import evt_scan_pkg::*;
#(
  parameter int unsigned LINES = 32,
  localparam int unsigned LW   = $clog2(LINES),
  localparam int unsigned PW   = LW + KIND_W
) (
  input  logic          held,
  input  logic [PW-1:0] ptr,
  output logic [KINDS-1:0] irq,
  output logic [LW-1:0] rd_line
);

  for (genvar k = 0; k < KINDS; k++) begin : g_lvl
    assign irq[k] = held && (ptr[KIND_W-1:0] == KIND_W'(k));
  end

  assign rd_line = held ? ptr[PW-1:KIND_W] : '0;

endmodule

// File: rtl/evt_scanner.sv
`timescale 1ns/1ps
module evt_scanner
  import evt_scan_pkg::*;
#(
  parameter int unsigned LINES = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LINES-1:0]         rx_evt,
  input  logic [LINES-1:0]         tx_evt,
  input  logic [LINES-1:0]         con_evt,
  input  logic [LINES-1:0]         coff_evt,
  input  logic [LINES-1:0]         line_rst,
  input  logic                     rd_stb,
  output logic [$clog2(LINES)-1:0] rd_line,
  output logic [3:0]               irq,
  output logic                     busy
);

  localparam int unsigned SLOTS = LINES * KINDS;
  localparam int unsigned PW    = $clog2(SLOTS);

  logic [SLOTS-1:0] set_mask;
  logic [SLOTS-1:0] rst_mask;
  logic [SLOTS-1:0] take_mask;
  logic [SLOTS-1:0] flags;
  logic [PW-1:0]    ptr;
  logic             held;
  logic             take;
  logic             hit;
  logic             any_set;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    assign set_mask[slot_of(l, EVK_RX)]   = rx_evt[l];
    assign set_mask[slot_of(l, EVK_TX)]   = tx_evt[l];
    assign set_mask[slot_of(l, EVK_CON)]  = con_evt[l];
    assign set_mask[slot_of(l, EVK_COFF)] = coff_evt[l];
    assign rst_mask[l*KINDS +: KINDS]     = {KINDS{line_rst[l]}};
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_take
    assign take_mask[s] = take && (ptr == PW'(s));
  end

  assign any_set = |set_mask;

  evt_flag_bank #(.SLOTS(SLOTS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_mask (set_mask),
    .clr_mask (rst_mask | take_mask),
    .flags    (flags)
  );

  evt_scan_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .flags    (flags),
    .rst_mask (rst_mask),
    .any_set  (any_set),
    .rd_stb   (rd_stb),
    .ptr      (ptr),
    .held     (held),
    .busy     (busy),
    .take     (take),
    .hit      (hit)
  );

  evt_irq_steer #(.LINES(LINES)) u_steer (
    .held    (held),
    .ptr     (ptr),
    .irq     (irq),
    .rd_line (rd_line)
  );

endmodule

// File: rtl/evt_scanner_chk.sv
`timescale 1ns/1ps
module evt_scanner_chk #(
  parameter int unsigned LINES = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [LINES-1:0]         rx_evt,
  input logic [LINES-1:0]         tx_evt,
  input logic [LINES-1:0]         con_evt,
  input logic [LINES-1:0]         coff_evt,
  input logic [LINES-1:0]         line_rst,
  input logic                     rd_stb,
  input logic [$clog2(LINES)-1:0] rd_line,
  input logic [3:0]               irq,
  input logic                     busy
);

  logic quiet_in;
  assign quiet_in = !(|rx_evt) && !(|tx_evt) && !(|con_evt) && !(|coff_evt) && !(|line_rst);

  // R4
  irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq));

  // R4
  lock_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && (irq != 4'b0)));

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq != 4'b0) && !rd_stb) |=> ($stable(irq) && $stable(rd_line) && !busy));

  // R6
  read_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq != 4'b0) && rd_stb) |=> (busy && (irq == 4'b0)));

  // R7
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (irq == 4'b0) && rd_stb && quiet_in) |=> (!busy && (irq == 4'b0)));

  // R12
  line_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq == 4'b0) |-> (rd_line == '0));

endmodule

bind evt_scanner evt_scanner_chk #(.LINES(LINES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_evt   (rx_evt),
  .tx_evt   (tx_evt),
  .con_evt  (con_evt),
  .coff_evt (coff_evt),
  .line_rst (line_rst),
  .rd_stb   (rd_stb),
  .rd_line  (rd_line),
  .irq      (irq),
  .busy     (busy)
);

// File: tb/evt_scanner_test.sv
`timescale 1ns/1ps
module evt_scanner_test;

  localparam int LINES = 32;
  localparam int SLOTS = LINES * 4;

  localparam logic [1:0] OP_SET  = 2'd0;
  localparam logic [1:0] OP_HOLD = 2'd1;
  localparam logic [1:0] OP_READ = 2'd2;
  localparam logic [1:0] OP_LRST = 2'd3;

  localparam int NV = 26;
  // {op, line, kind}
  localparam logic [8:0] VEC [0:NV-1] = '{
    {OP_SET, 5'd3, 2'd0}, {OP_SET, 5'd1, 2'd1}, {OP_SET, 5'd0, 2'd3},
    {OP_SET, 5'd31, 2'd2}, {OP_SET, 5'd20, 2'd0},
    {OP_READ, 5'd0, 2'd3}, {OP_READ, 5'd1, 2'd1}, {OP_READ, 5'd3, 2'd0},
    {OP_READ, 5'd20, 2'd0}, {OP_READ, 5'd31, 2'd2},
    {OP_SET, 5'd0, 2'd0}, {OP_SET, 5'd31, 2'd3},
    {OP_READ, 5'd0, 2'd0}, {OP_READ, 5'd31, 2'd3},
    {OP_SET, 5'd0, 2'd1}, {OP_SET, 5'd2, 2'd0},
    {OP_READ, 5'd0, 2'd1}, {OP_READ, 5'd2, 2'd0},
    {OP_SET, 5'd4, 2'd0}, {OP_HOLD, 5'd4, 2'd0},
    {OP_SET, 5'd5, 2'd0}, {OP_SET, 5'd5, 2'd3}, {OP_SET, 5'd6, 2'd1},
    {OP_LRST, 5'd5, 2'd0},
    {OP_READ, 5'd4, 2'd0}, {OP_READ, 5'd6, 2'd1}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [LINES-1:0] rx_evt = '0;
  logic [LINES-1:0] tx_evt = '0;
  logic [LINES-1:0] con_evt = '0;
  logic [LINES-1:0] coff_evt = '0;
  logic [LINES-1:0] line_rst = '0;
  logic             rd_stb = 1'b0;
  logic [4:0]       rd_line;
  logic [3:0]       irq;
  logic             busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  evt_scanner #(.LINES(LINES)) uut (
    .clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .tx_evt(tx_evt),
    .con_evt(con_evt), .coff_evt(coff_evt), .line_rst(line_rst),
    .rd_stb(rd_stb), .rd_line(rd_line), .irq(irq), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse_evt(input int line, input int kind);
    case (kind)
      0: rx_evt[line]   = 1'b1;
      1: tx_evt[line]   = 1'b1;
      2: con_evt[line]  = 1'b1;
      default: coff_evt[line] = 1'b1;
    endcase
    @(negedge clk);
    rx_evt = '0; tx_evt = '0; con_evt = '0; coff_evt = '0;
  endtask

  task automatic pulse_read();
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic wait_irq(input int lim, output int n);
    n = 0;
    while (irq == 4'b0 && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic expect_lock(input int line, input int kind, input string req);
    int n;
    wait_irq(400, n);
    check(irq == (4'b1 << kind), req, int'(irq), 1 << kind);
    check(rd_line == 5'(line), req, int'(rd_line), line);
    check(!busy, req, int'(busy), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int n;
    do_reset();
    @(negedge clk);
    // R11 reset state
    check(irq == 4'b0, "R11 irq after reset", int'(irq), 0);
    check(!busy, "R11 busy after reset", int'(busy), 0);
    check(rd_line == 5'd0, "R11 R12 rd_line after reset", int'(rd_line), 0);

    // table walk: R1 R3 R5 R6 R10 service order
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      int ln, kd;
      op = VEC[i][8:7];
      ln = int'(VEC[i][6:2]);
      kd = int'(VEC[i][1:0]);
      case (op)
        OP_SET:  pulse_evt(ln, kd);
        OP_HOLD: expect_lock(ln, kd, "R4 R5 held lock");
        OP_READ: begin
          expect_lock(ln, kd, "R1 R3 R6 R10 service order");
          pulse_read();
        end
        default: begin
          line_rst[ln] = 1'b1;
          @(negedge clk);
          line_rst = '0;
          check(irq == 4'b0001 && rd_line == 5'd4, "R10 lock kept over line clear",
                int'(rd_line), 4);
        end
      endcase
    end

    // R2 latency from reset pointer (last slot) to slot 5: 6 cycles
    do_reset();
    pulse_evt(1, 1);
    wait_irq(400, n);
    check(n == 6, "R2 scan latency", n, 6);
    check(irq == 4'b0010 && rd_line == 5'd1, "R1 line1 transmit", int'(irq), 2);

    // R8 empty circle: busy for exactly SLOTS cycles
    pulse_read();
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check(n == SLOTS, "R8 empty circle length", n, SLOTS);
    check(irq == 4'b0, "R8 idle after circle", int'(irq), 0);

    // R7 read while idle: no effect, pointer still at slot 5
    pulse_read();
    repeat (3) @(negedge clk);
    check(!busy && irq == 4'b0, "R7 idle read ignored", int'(busy), 0);
    pulse_evt(2, 2);
    wait_irq(400, n);
    check(n == 5, "R7 R2 pointer unmoved", n, 5);
    check(irq == 4'b0100 && rd_line == 5'd2, "R1 line2 carrier on", int'(rd_line), 2);

    // R9 event behind the pointer during a scan is still found
    pulse_read();
    pulse_evt(2, 3);
    expect_lock(2, 3, "R9 restart on event during scan");

    // R10 same-cycle line clear and event: event wins
    line_rst[7] = 1'b1;
    con_evt[7]  = 1'b1;
    @(negedge clk);
    line_rst = '0;
    con_evt  = '0;
    pulse_read();
    expect_lock(7, 2, "R10 set wins over line clear");

    // R11 reset while locked clears everything
    do_reset();
    @(negedge clk);
    check(irq == 4'b0 && !busy, "R11 reset while locked", int'(irq), 0);
    repeat (200) @(negedge clk);
    check(irq == 4'b0, "R11 flags cleared by reset", int'(irq), 0);
    check(rd_line == 5'd0, "R12 line zero when idle", int'(rd_line), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule